// File: doc/BRIEF.md
# Saturating Transmit Statistics Counters

This block keeps four small counters of transmit statistics and presents them to a host as one packed read-only word. The transmit path hands it one completion record per packet. The record gives the number of collisions the packet met, whether the packet had to defer, and whether that deferral was excessive. The block turns each record into at most one step for each counter. It does not detect collisions or deferrals on the medium itself.

Each counter stops at its maximum value and does not wrap. While any counter sits at its maximum, an interrupt request is held high. A host read returns all four counters in one word and clears them together.

Completion records arrive on a valid/ready stream. `ev_ready` is high in every cycle out of reset, so the block never applies back-pressure. A record is consumed in any cycle where `ev_valid` and `ev_ready` are both high. The host read is a one-cycle strobe, and its data comes back on the following cycle with `rd_valid`.

Top module: `tx_stat_counters`

## Requirements
- R1: `ev_ready` is high in every cycle out of reset, and a record counts in the cycle it is presented with `ev_valid` high. With `ev_valid` low, no counter changes, whatever the other event inputs hold.
- R2: Each counter stops at 15, and further qualifying records leave it at 15.
- R3: `irq` is high in every cycle in which at least one counter holds 15. It becomes high in the cycle after the edge that took that counter to 15.
- R4: A strobe on `rd_stb` gives `rd_valid` high for exactly one cycle, in the next cycle. `rd_data` then holds the counters as they stood at the strobe edge, packed as follows: bits [15:12] excessive-deferral, [11:8] deferral, [7:4] multiple-collision, [3:0] single-collision. The same edge clears every counter.
- R5: A single record moves each counter by at most one.
- R6: A record with `ev_collisions` equal to 1 increments the single-collision counter only.
- R7: A record with `ev_collisions` of 2 or more (2 to 16 in normal use) increments the multiple-collision counter only. A record with `ev_collisions` equal to 0 touches neither collision counter.
- R8: `ev_deferred` high adds one to the deferral counter. `ev_excess_defer` high adds one to the excessive-deferral counter. The two flags act independently.
- R9: A record and a read strobe in the same cycle behave as follows. The read returns the counts without that record, and the record then stands as a count of 1 in each counter it qualifies for.
- R10: `irq` is low in the cycle in which `rd_valid` is high.
- R11: After reset all counters are 0, and `irq` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Completion record present |
| ev_ready | output | 1 | Record accepted (high out of reset) |
| ev_collisions | input | 5 | Collisions seen by the packet |
| ev_deferred | input | 1 | Packet deferred at least once |
| ev_excess_defer | input | 1 | Packet deferral was excessive |
| rd_stb | input | 1 | Host read strobe, one cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Packed counters captured at the read |
| irq | output | 1 | At least one counter at 15 |

## Verification
Records are drawn at random for the collision count (0, 1, 2 to 16, and values above 16) and for the two deferral flags. This separates the single and multiple collision paths and confirms that the deferral fields move on their own. Reads are kept rare, so that counters run into saturation and the no-wrap and interrupt behaviour can be seen. Directed cases cover the following:
- a record that is presented with `ev_valid` low, to tell "ignored" apart from "counted";
- a read in the same cycle as a record, to show whether the record is lost or double-counted;
- a read just after saturation, to show that `irq` falls.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int unsigned NUM_FIELDS = 4;

  typedef enum int unsigned {
    FLD_SINGLE = 0,
    FLD_MULTI  = 1,
    FLD_DEFER  = 2,
    FLD_EXCESS = 3
  } field_e;
endpackage

// File: rtl/txstat_classifier.sv
module txstat_classifier
  import txstat_pkg::*;
#(
  parameter int unsigned COLL_W = 5
) (
  input  logic              take,
  input  logic [COLL_W-1:0] collisions,
  input  logic              deferred,
  input  logic              excess_defer,
  output logic [NUM_FIELDS-1:0] bump
);
  localparam logic [COLL_W-1:0] ONE = COLL_W'(1);
  localparam logic [COLL_W-1:0] TWO = COLL_W'(2);

  always_comb begin
    bump             = '0;
    bump[FLD_SINGLE] = take && (collisions == ONE);
    bump[FLD_MULTI]  = take && (collisions >= TWO);
    bump[FLD_DEFER]  = take && deferred;
    bump[FLD_EXCESS] = take && excess_defer;
  end
endmodule

// File: rtl/txstat_sat_counter.sv
module txstat_sat_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value,
  output logic             at_max
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base, nxt;

  always_comb begin
    base = clr ? '0 : value;
    nxt  = (inc && base != MAXV) ? base + CNT_W'(1) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end

  assign at_max = (value == MAXV);

  // R2: a saturated counter stays saturated until a clear
  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(value) == MAXV && !$past(clr)) |-> value == MAXV);

  // R4 / R9: after a clear at most the same-cycle record remains
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> value <= CNT_W'(1));

  // R5: at most one step per edge
  assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (value == $past(value) || value == $past(value) + CNT_W'(1)));

  // R1: no increment without a request
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && !$past(inc)) |-> $stable(value));
endmodule

// File: rtl/tx_stat_counters.sv
module tx_stat_counters
  import txstat_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned COLL_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_valid,
  output logic                        ev_ready,
  input  logic [COLL_W-1:0]           ev_collisions,
  input  logic                        ev_deferred,
  input  logic                        ev_excess_defer,
  input  logic                        rd_stb,
  output logic                        rd_valid,
  output logic [NUM_FIELDS*CNT_W-1:0] rd_data,
  output logic                        irq
);
  localparam int unsigned DATA_W = NUM_FIELDS * CNT_W;

  logic                  take;
  logic [NUM_FIELDS-1:0] bump;
  logic [NUM_FIELDS-1:0] full;
  logic [DATA_W-1:0]     packed_now;
  logic                  ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign ev_ready = ready_q;
  assign take     = ev_valid && ev_ready;

  txstat_classifier #(.COLL_W(COLL_W)) u_classify (
    .take         (take),
    .collisions   (ev_collisions),
    .deferred     (ev_deferred),
    .excess_defer (ev_excess_defer),
    .bump         (bump)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cnt
    txstat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rd_stb),
      .inc    (bump[g]),
      .value  (packed_now[g*CNT_W +: CNT_W]),
      .at_max (full[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= packed_now;
    end
  end

  assign irq = |full;

  // R4: read data appears exactly one cycle after the strobe
  assert_rd_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb) == rd_valid);

  // R10: the clearing read leaves no counter saturated
  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !irq);

  // R3: interrupt persists while no read intervenes
  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && !$past(rd_stb)) |-> irq);

  // R1: never back-pressure after the first cycle out of reset
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ev_ready);
endmodule

// File: tb/tx_stat_counters_bench.sv
`timescale 1ns/1ps
module tx_stat_counters_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [4:0]  ev_collisions = '0;
  logic        ev_deferred = 1'b0;
  logic        ev_excess_defer = 1'b0;
  logic        rd_stb = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned model [4];
  bit          done = 0;

  always #2.5 clk = ~clk;

  tx_stat_counters u_tx_stat_counters (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_collisions(ev_collisions), .ev_deferred(ev_deferred),
    .ev_excess_defer(ev_excess_defer), .rd_stb(rd_stb),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned sat_inc(int unsigned v, bit en);
    return (en && v < 15) ? v + 1 : v;
  endfunction

  function automatic logic [15:0] pack_model();
    return {model[3][3:0], model[2][3:0], model[1][3:0], model[0][3:0]};
  endfunction

  function automatic bit any_full();
    bit r = 0;
    for (int i = 0; i < 4; i++) if (model[i] == 15) r = 1;
    return r;
  endfunction

  // Drive one cycle at a negedge, then check at the following negedge
  task automatic step(bit v, int unsigned coll, bit dfr, bit exc, bit rd, string tag);
    logic [15:0] exp_rd;
    bit s, m;
    ev_valid = v; ev_collisions = 5'(coll); ev_deferred = dfr;
    ev_excess_defer = exc; rd_stb = rd;
    exp_rd = pack_model();
    if (rd) for (int i = 0; i < 4; i++) model[i] = 0;
    s = v && coll == 1;
    m = v && coll >= 2;
    model[0] = sat_inc(model[0], s);
    model[1] = sat_inc(model[1], m);
    model[2] = sat_inc(model[2], v && dfr);
    model[3] = sat_inc(model[3], v && exc);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0; rd_stb = 0;
    chk({tag, " R4 rd_valid"}, 32'(rd_valid), 32'(rd));
    if (rd) chk({tag, " R4 rd_data"}, 32'(rd_data), 32'(exp_rd));
    chk({tag, " R3 irq"}, 32'(irq), 32'(any_full()));
    chk({tag, " R1 ev_ready"}, 32'(ev_ready), 32'd1);
  endtask

  task automatic read_expect(logic [15:0] exp, string tag);
    chk({tag, " model"}, 32'(pack_model()), 32'(exp));
    step(0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 irq", 32'(irq), 0);
    chk("R11 rd_valid", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_expect(16'h0000, "R11 counts");

    // R1: ignored when not valid
    step(0, 1, 1, 1, 0, "R1 idle");
    read_expect(16'h0000, "R1 idle");
    // R6, R7, R8
    step(1, 1, 0, 0, 0, "R6");
    read_expect(16'h0001, "R6");
    step(1, 16, 0, 0, 0, "R7 sixteen");
    step(1, 2, 0, 0, 0, "R7 two");
    step(1, 0, 0, 0, 0, "R7 zero");
    read_expect(16'h0020, "R7");
    step(1, 3, 1, 1, 0, "R8 R5");
    read_expect(16'h1110, "R8 R5");
    // R2, R3: saturate single-collision counter
    for (int k = 0; k < 20; k++) step(1, 1, 0, 0, 0, "R2 R3 fill");
    chk("R3 irq at full", 32'(irq), 1);
    // R10: clearing read drops irq
    read_expect(16'h000F, "R10 R2");
    chk("R10 irq low", 32'(irq), 0);
    // R9: read and record in same cycle
    step(1, 1, 0, 0, 0, "R9 pre");
    step(1, 5, 1, 0, 1, "R9 same");
    read_expect(16'h0110, "R9 after");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      int unsigned c;
      int unsigned sel = $urandom_range(0, 9);
      c = (sel < 3) ? 0 : (sel < 6) ? 1 : (sel < 9) ? $urandom_range(2, 16)
                                                     : $urandom_range(17, 31);
      step($urandom_range(0, 3) != 0, c, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
           $urandom_range(0, 39) == 0, "rand R2 R5 R6 R7 R8 R9");
    end
    read_expect(pack_model(), "final R4");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule